// File: doc/BRIEF.md
# Bidirectional Timer with Compare Match

An 8-bit timer that counts one step per timer tick. The tick comes either from an internal prescaler enable or from an already synchronized tick from an external oscillator, and a select input picks between them. Four modes set the count pattern. Two modes count upward only: one wraps at the all-ones value, and the other clears after reaching the compare value. The other two modes count up and then back down, and reverse at a ceiling that is either the all-ones value or the compare value.

The count is compared with an active compare value on every tick. A match sets a sticky compare flag and toggles a waveform pin. An overflow flag marks a wrap past the all-ones value in the up-only modes, and a return to zero in the up/down modes. Software writes the compare value into a holding register. The hardware moves it into the active register at a safe point in the count sequence, so the waveform never sees a half-updated threshold. A small register-select bus loads the count, loads the compare holding register, clears flags by writing ones, and reads back all of this state.

Top module: `bidir_timer`

## Requirements
- R1: After reset the count, both compare registers, both flags and the waveform pin are zero, and the direction is upward.
- R2: With `src_sel`=0 only `tick_int` advances the timer, and with `src_sel`=1 only `tick_ext` does. The unselected tick has no effect.
- R3: Mode 0 counts up by one per tick, goes from 0xFF to 0x00, and sets the overflow flag on that wrap.
- R4: Mode 1 counts up and returns to 0x00 on the tick taken at the active compare value.
- R5: Modes 2 and 3 count up to a ceiling and then down to 0x00, reversing at each end. The ceiling is 0xFF in mode 2 and the active compare value in mode 3. The overflow flag is set on the tick taken at 0x00 while counting down, and not at the ceiling.
- R6: A tick taken while the count equals the active compare value sets the compare flag and toggles `wave`. No other event changes `wave`.
- R7: A write to address 1 loads only the holding register. The active compare value (read at address 3) takes the holding value on the tick taken at the ceiling in modes 0 and 1, and on the tick taken at 0x00 in modes 2 and 3.
- R8: A write to address 0 loads the count, and it wins over a tick in the same cycle. Compare-match detection is suppressed on the first tick after such a write.
- R9: Address 2 holds the flags: bit 0 is compare and bit 1 is overflow. Writing a one clears a bit and writing a zero leaves it unchanged. A hardware set in the same cycle wins over a clear. `irq_cmp` and `irq_ovf` follow the flags.
- R10: `rd_data` returns, without delay, the count at address 0, the holding register at 1, the flags at 2 and the active compare value at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_int | input | 1 | Prescaled internal tick enable |
| tick_ext | input | 1 | Synchronized external oscillator tick |
| src_sel | input | 1 | Tick source select (1 = external) |
| mode | input | 2 | Count mode 0..3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| count | output | 8 | Current count |
| wave | output | 1 | Compare-match toggle output |
| irq_cmp | output | 1 | Compare flag |
| irq_ovf | output | 1 | Overflow flag |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a tick that matches the compare value together with a software write of one to the compare flag. The bench drives both in one cycle and expects the flag to stay set. It then shows that a later clear with no match clears the flag, and that writing zero changes nothing. The second pair is a count load together with a tick. Here the loaded value must win, and the next tick must not raise a match even when the loaded value equals the compare value.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        MODE_FREE       = 2'd0,
        MODE_CLR_ON_CMP = 2'd1,
        MODE_UPDN_MAX   = 2'd2,
        MODE_UPDN_CMP   = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        REG_COUNT   = 2'd0,
        REG_CMP_BUF = 2'd1,
        REG_FLAGS   = 2'd2,
        REG_CMP_ACT = 2'd3
    } treg_e;

    localparam int FLAG_CMP_BIT = 0;
    localparam int FLAG_OVF_BIT = 1;

endpackage

// File: rtl/timer_tick_sel.sv
module timer_tick_sel (
    input  logic tick_int,
    input  logic tick_ext,
    input  logic src_sel,
    output logic tick
);
    always_comb begin
        tick = src_sel ? tick_ext : tick_int;
    end
endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmode_e       mode,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_buf_o,
    output logic [W-1:0] cmp_act_o,
    output logic         ev_match,
    output logic         ev_ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] hold;
        logic [W-1:0] act;
        logic         up;
        logic         blk;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic         updown;
    logic [W-1:0] top;
    logic         upd;

    always_comb begin
        st_d     = st_q;
        updown   = (mode == MODE_UPDN_MAX) || (mode == MODE_UPDN_CMP);
        top      = ((mode == MODE_FREE) || (mode == MODE_UPDN_MAX)) ? MAXV : st_q.act;
        ev_match = tick && !st_q.blk && (st_q.cnt == st_q.act);
        ev_ovf   = tick && (updown ? (!st_q.up && st_q.cnt == '0) : (st_q.cnt == MAXV));
        upd      = tick && (updown ? (st_q.cnt == '0) : (st_q.cnt == top));

        if (cmp_wr) st_d.hold = wr_data;
        if (upd)    st_d.act  = st_q.hold;

        if (tick) begin
            st_d.blk = 1'b0;
            if (!updown) begin
                st_d.cnt = (st_q.cnt == top) ? '0 : st_q.cnt + ONE;
            end else if (st_q.up) begin
                if (st_q.cnt == top) begin
                    st_d.up  = 1'b0;
                    st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - ONE;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.up  = 1'b1;
                    st_d.cnt = (top == '0) ? '0 : ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end

        if (cnt_wr) begin
            st_d.cnt = wr_data;
            st_d.blk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, hold: '0, act: '0, up: 1'b1, blk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cmp_buf_o = st_q.hold;
    assign cmp_act_o = st_q.act;

    // R8: a count write lands on the next edge
    a_r8_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (st_q.cnt == $past(wr_data)));

    // R3: free mode wraps from all ones to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MODE_FREE && st_q.cnt == MAXV) |=> (st_q.cnt == '0));

    // R7: active compare value moves only on a tick
    a_r7_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.act));

    // R5: counting down away from zero steps by one
    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && updown && !st_q.up && st_q.cnt != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - ONE));
endmodule

// File: rtl/timer_flags.sv
module timer_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_match,
    input  logic ev_ovf,
    input  logic clr_cmp,
    input  logic clr_ovf,
    output logic cmp_flag,
    output logic ovf_flag,
    output logic wave
);
    typedef struct packed {
        logic cmp;
        logic ovf;
        logic wave;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        fl_d.cmp  = (fl_q.cmp & ~clr_cmp) | ev_match;
        fl_d.ovf  = (fl_q.ovf & ~clr_ovf) | ev_ovf;
        fl_d.wave = fl_q.wave ^ ev_match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign cmp_flag = fl_q.cmp;
    assign ovf_flag = fl_q.ovf;
    assign wave     = fl_q.wave;

    // R9: a set wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |=> fl_q.cmp);

    // R9: a clear without a new overflow empties the bit
    a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !ev_ovf) |=> !fl_q.ovf);

    // R6: waveform toggles on a match
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |=> (fl_q.wave != $past(fl_q.wave)));

    // R6: waveform holds otherwise
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_match |=> $stable(fl_q.wave));
endmodule

// File: rtl/bidir_timer.sv
module bidir_timer
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_int,
    input  logic         tick_ext,
    input  logic         src_sel,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] count,
    output logic         wave,
    output logic         irq_cmp,
    output logic         irq_ovf
);
    logic         tick;
    logic         cnt_wr, cmp_wr, clr_cmp, clr_ovf;
    logic         ev_match, ev_ovf;
    logic [W-1:0] cmp_buf, cmp_act;
    tmode_e       mode_e;

    always_comb begin
        mode_e  = tmode_e'(mode);
        cnt_wr  = wr_en && (treg_e'(addr) == REG_COUNT);
        cmp_wr  = wr_en && (treg_e'(addr) == REG_CMP_BUF);
        clr_cmp = wr_en && (treg_e'(addr) == REG_FLAGS) && wr_data[FLAG_CMP_BIT];
        clr_ovf = wr_en && (treg_e'(addr) == REG_FLAGS) && wr_data[FLAG_OVF_BIT];
    end

    timer_tick_sel i_tick_sel (
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .src_sel  (src_sel),
        .tick     (tick)
    );

    timer_counter #(.W(W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode_e),
        .cnt_wr    (cnt_wr),
        .cmp_wr    (cmp_wr),
        .wr_data   (wr_data),
        .cnt_o     (count),
        .cmp_buf_o (cmp_buf),
        .cmp_act_o (cmp_act),
        .ev_match  (ev_match),
        .ev_ovf    (ev_ovf)
    );

    timer_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_match (ev_match),
        .ev_ovf   (ev_ovf),
        .clr_cmp  (clr_cmp),
        .clr_ovf  (clr_ovf),
        .cmp_flag (irq_cmp),
        .ovf_flag (irq_ovf),
        .wave     (wave)
    );

    always_comb begin
        rd_data = '0;
        unique case (treg_e'(addr))
            REG_COUNT:   rd_data = count;
            REG_CMP_BUF: rd_data = cmp_buf;
            REG_FLAGS: begin
                rd_data[FLAG_CMP_BIT] = irq_cmp;
                rd_data[FLAG_OVF_BIT] = irq_ovf;
            end
            REG_CMP_ACT: rd_data = cmp_act;
            default:     rd_data = '0;
        endcase
    end

    // R2: no selected tick and no load leaves the count unchanged
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(src_sel ? tick_ext : tick_int) && !cnt_wr) |=> $stable(count));

    // R10: flag readback matches the flag outputs
    a_r10_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
        (treg_e'(addr) == REG_FLAGS) |-> (rd_data[1:0] == {irq_ovf, irq_cmp}));
endmodule

// File: tb/test_bidir_timer.sv
module test_bidir_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_int = 1'b0, tick_ext = 1'b0, src_sel = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data, count;
    logic       wave, irq_cmp, irq_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bidir_timer i_bidir_timer (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
        .src_sel(src_sel), .mode(mode), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .count(count), .wave(wave),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    // op: 0 write(addr,data) 1 ticks(data) 2 read check(addr,exp) 3 set mode(data)
    localparam int NV = 41;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {2'd2, 2'd0, 8'h00, 8'h00, 4'd1},  // R1 count
        {2'd2, 2'd2, 8'h00, 8'h00, 4'd1},  // R1 flags
        {2'd0, 2'd1, 8'h05, 8'h00, 4'd7},
        {2'd2, 2'd1, 8'h00, 8'h05, 4'd10}, // R10 holding readback
        {2'd2, 2'd3, 8'h00, 8'h00, 4'd7},  // R7 active unchanged
        {2'd1, 2'd0, 8'd3,  8'h00, 4'd3},
        {2'd2, 2'd0, 8'h00, 8'h03, 4'd3},  // R3 counts up
        {2'd2, 2'd2, 8'h00, 8'h01, 4'd6},  // R6 match at 0
        {2'd0, 2'd2, 8'h01, 8'h00, 4'd9},
        {2'd2, 2'd2, 8'h00, 8'h00, 4'd9},  // R9 cleared
        {2'd0, 2'd0, 8'hFD, 8'h00, 4'd8},
        {2'd1, 2'd0, 8'd3,  8'h00, 4'd3},
        {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 wrap
        {2'd2, 2'd2, 8'h00, 8'h02, 4'd3},  // R3 overflow
        {2'd2, 2'd3, 8'h00, 8'h05, 4'd7},  // R7 loaded at top
        {2'd0, 2'd2, 8'h02, 8'h00, 4'd9},
        {2'd1, 2'd0, 8'd6,  8'h00, 4'd3},
        {2'd2, 2'd0, 8'h00, 8'h06, 4'd3},
        {2'd2, 2'd2, 8'h00, 8'h01, 4'd6},  // R6 match at 5
        {2'd3, 2'd0, 8'd1,  8'h00, 4'd4},
        {2'd0, 2'd2, 8'h03, 8'h00, 4'd9},
        {2'd0, 2'd0, 8'h00, 8'h00, 4'd8},
        {2'd1, 2'd0, 8'd6,  8'h00, 4'd4},
        {2'd2, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 cleared after compare
        {2'd2, 2'd2, 8'h00, 8'h01, 4'd4},  // R4 match, no overflow
        {2'd0, 2'd1, 8'h03, 8'h00, 4'd7},
        {2'd3, 2'd0, 8'd3,  8'h00, 4'd5},
        {2'd0, 2'd2, 8'h03, 8'h00, 4'd9},
        {2'd1, 2'd0, 8'd4,  8'h00, 4'd5},
        {2'd2, 2'd0, 8'h00, 8'h02, 4'd5},  // R5 reversed at 3
        {2'd2, 2'd2, 8'h00, 8'h01, 4'd6},
        {2'd1, 2'd0, 8'd3,  8'h00, 4'd5},
        {2'd2, 2'd0, 8'h00, 8'h01, 4'd5},  // R5 reversed at bottom
        {2'd2, 2'd2, 8'h00, 8'h03, 4'd5},  // R5 overflow at bottom
        {2'd2, 2'd3, 8'h00, 8'h03, 4'd7},
        {2'd3, 2'd0, 8'd2,  8'h00, 4'd5},
        {2'd0, 2'd2, 8'h03, 8'h00, 4'd9},
        {2'd0, 2'd0, 8'hFE, 8'h00, 4'd8},
        {2'd1, 2'd0, 8'd3,  8'h00, 4'd5},
        {2'd2, 2'd0, 8'h00, 8'hFD, 4'd5},  // R5 reversed at 0xFF
        {2'd2, 2'd2, 8'h00, 8'h00, 4'd5}   // R5 no overflow at ceiling
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_int = 1'b1;
            @(negedge clk); tick_int = 1'b0;
        end
    endtask

    task automatic ext_tick;
        @(negedge clk); tick_ext = 1'b1;
        @(negedge clk); tick_ext = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic write_with_tick(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; tick_int = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_int = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 wave", {7'd0, wave}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v][23:22])
                2'd0: bus_write(VEC[v][21:20], VEC[v][19:12]);
                2'd1: ticks(int'(VEC[v][19:12]));
                2'd2: read_chk(VEC[v][21:20], VEC[v][11:4], $sformatf("R%0d vec %0d", VEC[v][3:0], v));
                default: begin @(negedge clk); mode = VEC[v][13:12]; end
            endcase
        end
        check("R6 wave after four matches", {7'd0, wave}, 8'h00);

        // R2: tick source selection
        @(negedge clk); mode = 2'd0;
        bus_write(2'd0, 8'h10);
        ext_tick();
        #1; check("R2 ext ignored when internal", count, 8'h10);
        @(negedge clk); src_sel = 1'b1;
        ticks(1);
        #1; check("R2 int ignored when external", count, 8'h10);
        ext_tick();
        #1; check("R2 ext advances", count, 8'h11);
        @(negedge clk); src_sel = 1'b0;

        // R8: load blocks the next match; load beats a tick
        bus_write(2'd0, 8'h03);
        ticks(1);
        #1; check("R8 blocked match count", count, 8'h04);
        read_chk(2'd2, 8'h00, "R8 no flag on blocked tick");
        write_with_tick(2'd0, 8'h02);
        #1; check("R8 write beats tick", count, 8'h02);
        ticks(2);
        #1; check("R8 count after block released", count, 8'h04);
        check("R6 match flag after release", {7'd0, irq_cmp}, 8'h01);
        check("R6 wave toggled", {7'd0, wave}, 8'h01);

        // R9: set beats clear in the same cycle
        bus_write(2'd2, 8'h01);
        read_chk(2'd2, 8'h00, "R9 clear by one");
        bus_write(2'd0, 8'h02);
        ticks(1);
        write_with_tick(2'd2, 8'h01);
        read_chk(2'd2, 8'h01, "R9 set wins over clear");
        bus_write(2'd2, 8'h00);
        read_chk(2'd2, 8'h01, "R9 zero write no effect");
        bus_write(2'd2, 8'h01);
        read_chk(2'd2, 8'h00, "R9 cleared");
        bus_write(2'd0, 8'hFF);
        ticks(1);
        #1; check("R9 irq_ovf follows flag", {7'd0, irq_ovf}, 8'h01);
        check("R3 wrap from load", count, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule